// File: doc/BRIEF.md
# ADC Conversion Strobe and Readout Gate Generator

This block produces the two periodic waveforms that drive a fast SAR converter with a serial data output. The first is a conversion strobe. Its rising edge starts the sampling of the analog input, and it stays high for a programmed number of reference clock cycles. The second is a clock-gate enable. It shares the strobe's period and phase, opens a programmed number of cycles after the strobe rises, and stays open for exactly one reference cycle per data bit. One cycle after the gate closes, a single-cycle pulse tells capture logic that the sample is complete.

All timing inputs are counted in reference clock cycles: period, strobe high time, gate offset and bit count. Software converts a rate in Hz into a period count beforehand; the block itself does no such conversion. The configuration is sampled when streaming starts and again at each period boundary. A change made in the middle of a period therefore never shortens or stretches a pulse. If the configuration is inconsistent, an error flag is raised, and the block refuses to start or stops at the next boundary. When the enable input is dropped, both waveforms go low at once.

Top module: `adc_cnv_timer`

## Requirements
- R1: While `enable` is low, and in the cycle after it is sampled low, `cnv_o`, `gate_o` and `burst_done_o` are all low; after reset all three are low.
- R2: Cycle 0 of a period is the first cycle after the clock edge that samples `enable` high with a valid configuration. `cnv_o` is high in phase cycles 0 to `strobe_cyc`-1 of every period, and a period lasts `period_cyc` cycles.
- R3: `gate_o` is high in phase cycles `offset_cyc` to `offset_cyc`+`bit_cnt`-1 of every period. This gives exactly `bit_cnt` high cycles per period, in the same period as `cnv_o`.
- R4: `burst_done_o` is high for one cycle, in the phase cycle right after the last high cycle of `gate_o`, in every period.
- R5: `cfg_err_o` is high, combinationally from the inputs, when `strobe_cyc` is 0, when `bit_cnt` is 0, or when `strobe_cyc`+`offset_cyc`+`bit_cnt` exceeds `period_cyc`.
- R6: If `enable` is high while `cfg_err_o` is high and the block is idle, the block does not start and all outputs stay low.
- R7: A configuration change made during a period has no effect until the period ends. The new values apply from the next cycle 0.
- R8: If `cfg_err_o` is high at the last cycle of a period, streaming stops and all outputs are low from the next cycle.
- R9: When `enable` drops in the middle of a period, the outputs are low from the next cycle. A later enable starts a fresh period at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start (high) / stop (low) streaming |
| period_cyc | input | CW | Sample period in cycles |
| strobe_cyc | input | CW | Conversion strobe high time in cycles |
| offset_cyc | input | CW | Gate start delay from strobe rise, in cycles |
| bit_cnt | input | NBW | Data bits per sample (gate length in cycles) |
| cnv_o | output | 1 | Conversion strobe |
| gate_o | output | 1 | Readout clock gate enable |
| burst_done_o | output | 1 | One-cycle pulse after the last gated cycle |
| cfg_err_o | output | 1 | Configuration inconsistent |

## Verification
Every output is decoded from one phase counter and one configuration snapshot. A counter that is off by one therefore moves the strobe edge, the gate edges and the done pulse within the same period. A bad snapshot shows up no later than the first period boundary after the fault, because both the length and the placement of the pulses change there. A run flag left wrong shows as activity in the cycle after `enable` is sampled low, or as silence in the cycle after a valid start.

// File: rtl/adc_cnv_timer.sv
module adc_cnv_timer #(
  parameter int CW  = 16,
  parameter int NBW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [CW-1:0]  period_cyc,
  input  logic [CW-1:0]  strobe_cyc,
  input  logic [CW-1:0]  offset_cyc,
  input  logic [NBW-1:0] bit_cnt,
  output logic           cnv_o,
  output logic           gate_o,
  output logic           burst_done_o,
  output logic           cfg_err_o
);
  localparam int SW = CW + 2;

  logic           running;
  logic [CW-1:0]  cnt, per_q, hi_q, ofs_q;
  logic [NBW-1:0] nb_q;
  logic           done_q;

  wire [SW-1:0] need     = SW'(strobe_cyc) + SW'(offset_cyc) + SW'(bit_cnt);
  wire [SW-1:0] gate_end = SW'(ofs_q) + SW'(nb_q);
  wire          last     = (cnt == per_q - 1'b1);
  wire          accept   = enable && !cfg_err_o;

  assign cfg_err_o    = (strobe_cyc == '0) || (bit_cnt == '0) || (need > SW'(period_cyc));
  assign cnv_o        = running && (cnt < hi_q);
  assign gate_o       = running && (cnt >= ofs_q) && (SW'(cnt) < gate_end);
  assign burst_done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      per_q   <= '0;
      hi_q    <= '0;
      ofs_q   <= '0;
      nb_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= running && enable && (SW'(cnt) + 1'b1 == gate_end);
      if (!enable) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (!running || last) begin
        running <= accept;
        cnt     <= '0;
        if (accept) begin
          per_q <= period_cyc;
          hi_q  <= strobe_cyc;
          ofs_q <= offset_cyc;
          nb_q  <= bit_cnt;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_cnv_timer_chk.sv
module adc_cnv_timer_chk #(
  parameter int CW  = 16,
  parameter int NBW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           cnv_o,
  input logic           gate_o,
  input logic           burst_done_o,
  input logic           running,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  per_q,
  input logic [CW-1:0]  hi_q,
  input logic [CW-1:0]  ofs_q,
  input logic [NBW-1:0] nb_q
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(enable) && $past(rst_n)) |-> (!cnv_o && !gate_o && !burst_done_o));

  assert_strobe_at_phase0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> (cnt == '0));

  assert_gate_at_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (cnt == ofs_q));

  assert_done_after_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done_o |-> ($past(gate_o) && !gate_o));

  assert_valid_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0) |-> (hi_q != '0 && nb_q != '0 &&
      ((CW+2)'(hi_q) + (CW+2)'(ofs_q) + (CW+2)'(nb_q) <= (CW+2)'(per_q))));

  assert_cfg_held_midperiod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != per_q - 1'b1) |=> $stable({per_q, hi_q, ofs_q, nb_q}));
endmodule

bind adc_cnv_timer adc_cnv_timer_chk #(.CW(CW), .NBW(NBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cnv_o(cnv_o), .gate_o(gate_o),
  .burst_done_o(burst_done_o), .running(running), .cnt(cnt), .per_q(per_q),
  .hi_q(hi_q), .ofs_q(ofs_q), .nb_q(nb_q)
);

// File: tb/test_adc_cnv_timer.sv
module test_adc_cnv_timer;
  localparam int CW = 16, NBW = 5;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [CW-1:0] period_cyc = '0, strobe_cyc = '0, offset_cyc = '0;
  logic [NBW-1:0] bit_cnt = '0;
  logic cnv_o, gate_o, burst_done_o, cfg_err_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_cnv_timer #(.CW(CW), .NBW(NBW)) i_adc_cnv_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_cyc(period_cyc),
    .strobe_cyc(strobe_cyc), .offset_cyc(offset_cyc), .bit_cnt(bit_cnt),
    .cnv_o(cnv_o), .gate_o(gate_o), .burst_done_o(burst_done_o), .cfg_err_o(cfg_err_o));

  // period, strobe, offset, bits
  localparam int VEC [6][4] = '{
    '{10, 2, 3, 4}, '{8, 1, 0, 7}, '{30, 20, 2, 8},
    '{5, 1, 1, 3},  '{64, 10, 36, 18}, '{18, 4, 6, 8}
  };

  task automatic set_cfg(int p, int h, int o, int n);
    period_cyc = CW'(p); strobe_cyc = CW'(h); offset_cyc = CW'(o); bit_cnt = NBW'(n);
  endtask

  task automatic expect3(string tag, logic c, logic g, logic d);
    checks++;
    if (cnv_o !== c || gate_o !== g || burst_done_o !== d) begin
      fails++;
      $display("FAIL %s t=%0t actual cnv/gate/done=%b%b%b expected=%b%b%b",
               tag, $time, cnv_o, gate_o, burst_done_o, c, g, d);
    end
  endtask

  task automatic chk_phase(string tag, int k, int p, int h, int o, int n);
    int ph = k % p;
    logic d = (k >= 1) && (((k - 1) % p) == o + n - 1);
    expect3(tag, ph < h, (ph >= o) && (ph < o + n), d);
  endtask

  task automatic chk_err(string tag, logic e);
    checks++;
    if (cfg_err_o !== e) begin
      fails++;
      $display("FAIL %s actual cfg_err=%b expected=%b", tag, cfg_err_o, e);
    end
  endtask

  task automatic stop_and_settle();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect3("R1 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect3("R1 idle", 1'b0, 1'b0, 1'b0);

    for (int v = 0; v < 6; v++) begin
      stop_and_settle();
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      #1 chk_err("R5 valid vector", 1'b0);
      expect3("R1 disabled", 1'b0, 1'b0, 1'b0);
      enable = 1'b1;
      for (int k = 0; k < 2 * VEC[v][0] + 1; k++) begin
        @(negedge clk);
        chk_phase("R2 R3 R4 vector", k, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      end
    end

    // R5 error decode
    stop_and_settle();
    set_cfg(10, 0, 1, 2); #1 chk_err("R5 zero strobe", 1'b1);
    set_cfg(10, 2, 1, 0); #1 chk_err("R5 zero bits", 1'b1);
    set_cfg(10, 3, 3, 5); #1 chk_err("R5 sum over period", 1'b1);
    set_cfg(10, 3, 2, 5); #1 chk_err("R5 sum equals period", 1'b0);

    // R6 invalid config at start
    set_cfg(10, 3, 3, 5);
    @(negedge clk); enable = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); expect3("R6 no start", 1'b0, 1'b0, 1'b0);
    end

    // R7 change mid-period
    stop_and_settle();
    set_cfg(10, 2, 3, 4); enable = 1'b1;
    for (int k = 0; k < 22; k++) begin
      @(negedge clk);
      if (k < 10) chk_phase("R7 old cfg", k, 10, 2, 3, 4);
      else        chk_phase("R7 new cfg", k - 10, 6, 3, 1, 2);
      if (k == 4) set_cfg(6, 3, 1, 2);
    end

    // R8 invalid at boundary
    stop_and_settle();
    set_cfg(10, 2, 3, 4); enable = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k < 10) chk_phase("R8 before boundary", k, 10, 2, 3, 4);
      else        expect3("R8 stopped", 1'b0, 1'b0, 1'b0);
      if (k == 6) set_cfg(10, 9, 2, 4);
    end

    // R9 disable mid-period then restart
    stop_and_settle();
    set_cfg(10, 2, 3, 4); enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk_phase("R9 running", k, 10, 2, 3, 4);
    end
    enable = 1'b0;
    @(negedge clk); expect3("R9 stop next cycle", 1'b0, 1'b0, 1'b0);
    @(negedge clk); expect3("R1 stays low", 1'b0, 1'b0, 1'b0);
    enable = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); chk_phase("R9 fresh period", k, 10, 2, 3, 4);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule